// File: doc/BRIEF.md
# Band-Selectable Quadrature Clock Divider

This block turns a fast oscillator clock (intended range 100 to 200 MHz) into a four-phase local-oscillator signal for one of nine HF amateur bands. A cascade of up to four divide-by-two prescaler stages comes first. Each stage can be switched in or out. A two-flop twisted-ring counter follows and divides by four. The overall ratio is therefore 4, 8, 16, 32 or 64 input cycles per output cycle.

A 4-bit band code picks the ratio. The two ring bits and their complements give I, Q, /I and /Q. The phases are spaced a quarter period apart, and each has a 50% duty cycle.

The whole block runs in the input clock domain. The prescaler stages are enable-gated toggle flops, not ripple clocks. A new band code takes effect only when the ring leaves its all-zero phase, which is the rising edge of I. Every output period is therefore whole and uniform.

Top module: `qlo_divider`

## Requirements
- R1: While `rst` is high at a clock edge, the ring and all prescaler flops clear: after that edge I=0, Q=0, /I=1, /Q=1. On the first edge after `rst` falls, I rises.
- R2: Band codes map to ratios as follows: code 0 gives 64; code 1 gives 32; codes 2 and 3 give 16; codes 4 to 7 give 8; code 8 gives 4. A ratio of 4·2^k uses the k lowest prescaler stages.
- R3: Codes 9 to 15 are unused and select ratio 4, with no prescaler stage active.
- R4: With the band code held, every period of I lasts exactly the selected ratio in input cycles. I is high for exactly half of each period.
- R5: Q rises exactly one quarter of the ratio after each rising edge of I, so Q lags I by 90 degrees.
- R6: /I is always the complement of I, and /Q is always the complement of Q.
- R7: The band code is sampled only on the clock edge at which I rises. A change made partway through a period leaves that period at its old length. The period that follows uses the new ratio.
- R8: The pair (I,Q) steps through 00, 10, 11, 01 in that order, and only one of the two changes at any edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| band_code | input | 4 | Band select code (0 to 8 valid; others select ratio 4) |
| lo_i | output | 1 | In-phase LO output |
| lo_q | output | 1 | Quadrature LO output, lags `lo_i` by a quarter period |
| lo_ib | output | 1 | Complement of `lo_i` |
| lo_qb | output | 1 | Complement of `lo_q` |

## Verification
The assertions assume that `band_code` is synchronous to `clk` and settles before each rising edge. They also assume that reset is asserted from the very first edge, so that every `$past` value is a defined register state. The stimulus meets both conditions. It drives the band code and reset only on falling clock edges, and it holds reset high from time zero for several cycles. The random codes cover the unused range as well as the nine bands. One directed case changes the code in the middle of a long period to exercise the deferred switch.

// File: rtl/qlo_pkg.sv
package qlo_pkg;

    localparam int PRE_STAGES = 4;
    localparam int CODE_W     = 4;
    localparam int NUM_BANDS  = 9;

    // Band codes, lowest frequency first
    typedef enum logic [3:0] {
        BAND_160M = 4'd0,
        BAND_80M  = 4'd1,
        BAND_40M  = 4'd2,
        BAND_30M  = 4'd3,
        BAND_20M  = 4'd4,
        BAND_17M  = 4'd5,
        BAND_15M  = 4'd6,
        BAND_12M  = 4'd7,
        BAND_10M  = 4'd8
    } band_e;

    // Twisted-ring phases in stepping order; bit 0 is I, bit 1 is Q
    typedef enum logic [1:0] {
        PH_0 = 2'b00,
        PH_1 = 2'b01,
        PH_2 = 2'b11,
        PH_3 = 2'b10
    } ring_e;

    // Number of active divide-by-two stages for a band code
    function automatic int unsigned stages_for(input int unsigned code);
        case (code)
            32'(BAND_160M):                       return 4;
            32'(BAND_80M):                        return 3;
            32'(BAND_40M), 32'(BAND_30M):         return 2;
            32'(BAND_20M), 32'(BAND_17M),
            32'(BAND_15M), 32'(BAND_12M):         return 1;
            default:                              return 0;
        endcase
    endfunction

endpackage

// File: rtl/qlo_band_latch.sv
module qlo_band_latch
    import qlo_pkg::*;
#(
    parameter int NUM_STAGES = PRE_STAGES,
    parameter int CODE_W_P   = CODE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [CODE_W_P-1:0]   band_code,
    output logic [NUM_STAGES-1:0] stage_en
);

    int unsigned                  want;
    logic        [NUM_STAGES-1:0] next_en;

    // Thermometer mask: the lowest 'want' stages are active
    always_comb begin
        want = stages_for(32'(band_code));
        if (want > NUM_STAGES) want = NUM_STAGES;
        for (int j = 0; j < NUM_STAGES; j++) begin
            next_en[j] = (j < int'(want));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       stage_en <= '0;
        else if (load) stage_en <= next_en;
    end

    // R7: the mask moves only on a load edge
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(stage_en) |-> $past(load));

    // R2: the mask is always a thermometer code
    assert_thermo_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot({1'b0, stage_en} + 1'b1));

    // R3: unused codes leave every prescaler stage bypassed
    assert_unused_code_R3: assert property (@(posedge clk) disable iff (rst)
        (load && (32'(band_code) >= NUM_BANDS)) |=> (stage_en == '0));

endmodule

// File: rtl/qlo_prescaler.sv
module qlo_prescaler
    import qlo_pkg::*;
#(
    parameter int NUM_STAGES = PRE_STAGES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_STAGES-1:0] stage_en,
    output logic                  tick
);

    logic [NUM_STAGES-1:0] q;
    logic [NUM_STAGES:0]   t;

    assign t[0] = 1'b1;

    // Enable chain: an active stage passes every second pulse, a bypassed one passes all
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_chain
        assign t[g+1] = stage_en[g] ? (t[g] & q[g]) : t[g];
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < NUM_STAGES; j++) begin
            if (rst || !stage_en[j]) q[j] <= 1'b0;
            else if (t[j])           q[j] <= ~q[j];
        end
    end

    assign tick = t[NUM_STAGES];

    // R4: an output pulse leaves every stage back at zero
    assert_wrap_clear_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> (q == '0));

endmodule

// File: rtl/qlo_ring.sv
module qlo_ring
    import qlo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    output ring_e state
);

    always_ff @(posedge clk) begin
        if (rst)      state <= PH_0;
        else if (adv) state <= ring_e'({state[0], ~state[1]});
    end

    // R8: one bit of the ring changes per edge at most
    assert_gray_step_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(state ^ $past(state)) <= 1);

    // R4: the ring only moves on a prescaler pulse
    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state));

endmodule

// File: rtl/qlo_divider.sv
module qlo_divider
    import qlo_pkg::*;
#(
    parameter int NUM_STAGES = PRE_STAGES,
    parameter int CODE_W_P   = CODE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CODE_W_P-1:0] band_code,
    output logic                lo_i,
    output logic                lo_q,
    output logic                lo_ib,
    output logic                lo_qb
);

    logic [NUM_STAGES-1:0] stage_en;
    logic                  tick;
    logic                  load;
    ring_e                 ring;

    // A new ratio is taken only as the ring leaves phase zero (I rising)
    assign load = tick && (ring == PH_0);

    qlo_band_latch #(.NUM_STAGES(NUM_STAGES), .CODE_W_P(CODE_W_P)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .band_code (band_code),
        .stage_en  (stage_en)
    );

    qlo_prescaler #(.NUM_STAGES(NUM_STAGES)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .stage_en (stage_en),
        .tick     (tick)
    );

    qlo_ring u_ring (
        .clk   (clk),
        .rst   (rst),
        .adv   (tick),
        .state (ring)
    );

    assign lo_i  = ring[0];
    assign lo_q  = ring[1];
    assign lo_ib = ~ring[0];
    assign lo_qb = ~ring[1];

    // R1: reset leaves I and Q low
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!lo_i && !lo_q));

    // R7: I only rises on a load edge
    assert_rise_loads_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_i) |-> $past(load));

endmodule

// File: tb/sim_qlo_divider.sv
`timescale 1ns/1ps
module sim_qlo_divider;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] band_code = 4'd0;
    logic       lo_i, lo_q, lo_ib, lo_qb;

    int checks = 0;
    int errors = 0;
    int comp_bad = 0;
    int gray_bad = 0;
    logic pi = 1'b0, pq = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;

    qlo_divider u0 (
        .clk(clk), .rst(rst), .band_code(band_code),
        .lo_i(lo_i), .lo_q(lo_q), .lo_ib(lo_ib), .lo_qb(lo_qb)
    );

    function automatic int ratio_of(input int code);
        case (code)
            0:          return 64;
            1:          return 32;
            2, 3:       return 16;
            4, 5, 6, 7: return 8;
            default:    return 4;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R6 and R8 monitors, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (lo_ib !== ~lo_i || lo_qb !== ~lo_q) comp_bad++;
            if (((lo_i ^ pi) + (lo_q ^ pq)) > 1) gray_bad++;
            if (lo_i && !pi && lo_q) gray_bad++;
        end
        pi = lo_i;
        pq = lo_q;
    end

    task automatic wait_rise();
        logic p;
        p = lo_i;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if (lo_i && !p) return;
            p = lo_i;
        end
        errors++;
        $display("FAIL R4: no rising edge on I, actual 0 expected 1");
    endtask

    // Counts from one observed I rise to the next
    task automatic measure(output int per, output int high, output int qlag);
        logic p, pq2;
        int cnt;
        per = 0; high = 0; qlag = 0; cnt = 0;
        p = lo_i; pq2 = lo_q;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            cnt++;
            if (!lo_i && p && high == 0) high = cnt;
            if (lo_q && !pq2 && qlag == 0) qlag = cnt;
            if (lo_i && !p) begin per = cnt; return; end
            p = lo_i; pq2 = lo_q;
        end
    endtask

    task automatic run_code(input int code);
        int per, high, qlag, r;
        band_code = 4'(code);
        wait_rise();
        measure(per, high, qlag);
        r = ratio_of(code);
        if (code >= 9) check("R3 unused code period", per, r);
        else           check("R2 band period", per, r);
        check("R4 high time", high, r / 2);
        check("R5 Q lag", qlag, r / 4);
    endtask

    initial begin
        int per, high, qlag, cnt;
        logic p;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 I in reset", int'(lo_i), 0);
        check("R1 Q in reset", int'(lo_q), 0);
        check("R1 /I in reset", int'(lo_ib), 1);
        check("R1 /Q in reset", int'(lo_qb), 1);
        band_code = 4'd8;
        rst = 1'b0;
        @(negedge clk);
        check("R1 I rises on first edge", int'(lo_i), 1);

        // directed: every valid band, then the unused codes
        for (int c = 0; c < 9; c++) run_code(c);
        run_code(9);
        run_code(15);

        // R7: change mid-period from ratio 64 to ratio 4
        band_code = 4'd0;
        wait_rise();
        wait_rise();
        repeat (10) @(negedge clk);
        band_code = 4'd8;
        cnt = 10;
        p = lo_i;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            cnt++;
            if (lo_i && !p) break;
            p = lo_i;
        end
        check("R7 period in progress keeps old ratio", cnt, 64);
        measure(per, high, qlag);
        check("R7 next period uses new ratio", per, 4);

        // constrained random codes
        for (int k = 0; k < 24; k++) run_code(int'($urandom_range(15, 0)));

        check("R6 complement outputs", comp_bad, 0);
        check("R8 single-bit phase steps", gray_bad, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule